// File: doc/BRIEF.md
# Serial EEPROM Auto-Loader with Host Pin Override

This block sits between a controller and a three-wire serial EEPROM that understands the common 64-word by 16-bit read command (a start bit, a two-bit opcode, then an address, with the data returned most significant bit first). When reset is released, the block checks whether a memory is fitted. If one is, it walks the whole address range and reads every word by driving chip select, serial clock and data-in itself. Every bit phase is paced by a slow time-base enable, not by the system clock. Each finished word leaves the block on a valid/ready stream together with its address.

Whether a memory is fitted is decided during reset. The block holds the level of the serial-clock pin as it stands on the last system clock edge while reset is asserted. A board with a memory pulls that pin high and a board without one pulls it low. When there is no memory, or once the load has ended, a small host register drives the three output lines directly so that software can bit-bang the device. Reading the same register returns the live data-out level, the busy and detect flags and the two output bits. While the load is running, the engine owns the pins and host writes are dropped.

The word stream applies back-pressure. `word_valid` stays high, with address and data held steady, until `word_ready` is sampled high. The engine does not start the next word until the current one has been accepted. With `word_ready` tied high, each word appears as a single-cycle strobe.

Top module: `eeprom_loader`

## Requirements
- R1: `host_rdata[4]` (detect) equals the level of `ee_sk_sense` on the last rising clock edge with `rst_n` low, and it does not change while `rst_n` stays high.
- R2: With detect 0, `load_done` is high from the first clock edge after reset release, busy is never set, and the pins show only host register values.
- R3: With detect 1, the block reads exactly NUM_WORDS words at ascending addresses starting at 0, and then sets `load_done`.
- R4: Each word read holds `ee_cs` high and presents 9 command bits on `ee_di`, sampled by the memory on rising `ee_sk`: 1, 1, 0, then the 6-bit address MSB first.
- R5: After the command, 16 further rising `ee_sk` edges each fetch one data bit, MSB first. The level on `ee_do` during each high clock phase becomes that bit of `word_data`.
- R6: During a load, `ee_sk` changes only on a clock edge at which `tick` was high, and `ee_sk` is never high while `ee_cs` is low.
- R7: Between two consecutive word reads, `ee_cs` is low across at least one sampled `tick`.
- R8: `word_valid` with `word_ready` low holds `word_valid`, `word_addr` and `word_data` unchanged on the next cycle. The next word starts only after the handshake.
- R9: `host_rdata[3]` (busy) is high from the first cycle after reset until the last word is accepted. Host writes made while busy are dropped and are not visible later.
- R10: When not busy, a host write sets `ee_cs`, `ee_sk` and `ee_di` from `host_wdata[2]`, `[1]` and `[0]` on the next cycle. `host_rdata[2:1]` read those bits back and `host_rdata[0]` shows the live `ee_do` level.
- R11: `load_done` rises on the cycle after the last word is accepted, or immediately when no memory is detected, and it is never high together with busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base enable, one pulse per memory bit phase |
| ee_sk_sense | input | 1 | Level sensed on the serial-clock pin, used for detection |
| ee_do | input | 1 | Memory data-out |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Memory data-in |
| host_wr | input | 1 | Host register write strobe |
| host_wdata | input | 3 | {chip select, serial clock, data-in} values to drive |
| host_rdata | output | 5 | {detect, busy, chip select, serial clock, data-out} |
| load_done | output | 1 | Automatic load finished or skipped |
| word_valid | output | 1 | Loaded word available |
| word_ready | input | 1 | Consumer accepts the word |
| word_addr | output | ADDR_W | Address of the loaded word |
| word_data | output | DATA_W | Loaded word |

## Verification
The hardest case to produce from the ports is a detect value taken from the last reset edge only. The stimulus drives the sense pin to the opposite level during earlier reset cycles, sets the wanted level just before the final reset edge, and flips it again right after release. A host write is also placed inside a running load, followed later by a read of the pins once the load has finished, to show that the write left no trace. The last run pairs a slow time base with a pseudo-random ready pattern, so that stalls land both between bit phases and in the middle of the inter-word gap.

// File: rtl/eel_pkg.sv
package eel_pkg;
  typedef enum logic [2:0] {
    ST_START,
    ST_GAP,
    ST_LO,
    ST_HI,
    ST_WAIT,
    ST_DONE
  } eng_state_t;

  // start bit 1 followed by read opcode 10
  localparam logic [2:0] READ_PREFIX = 3'b110;
endpackage

// File: rtl/eel_presence.sv
module eel_presence (
  input  logic clk,
  input  logic rst_n,
  input  logic sk_sense,
  output logic detect
);
  // keeps the level seen on the final edge with reset low
  always_ff @(posedge clk) begin
    if (!rst_n) detect <= sk_sense;
  end

  a_r1_detect_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(detect));
endmodule

// File: rtl/eel_host_port.sv
module eel_host_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       host_wr,
  input  logic [2:0] host_wdata,
  output logic [2:0] pin_reg
);
  always_ff @(posedge clk) begin
    if (!rst_n)                pin_reg <= '0;
    else if (host_wr && !busy) pin_reg <= host_wdata;
  end

  a_r9_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr) |=> $stable(pin_reg));
endmodule

// File: rtl/eel_engine.sv
module eel_engine
  import eel_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int NUM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              detect,
  input  logic              ee_do,
  output logic              eng_cs,
  output logic              eng_sk,
  output logic              eng_di,
  output logic              busy,
  output logic              done,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [ADDR_W-1:0] word_addr,
  output logic [DATA_W-1:0] word_data
);
  localparam int CMD_BITS   = 3 + ADDR_W;
  localparam int TOTAL_BITS = CMD_BITS + DATA_W;
  localparam int IDX_W      = $clog2(TOTAL_BITS);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);

  eng_state_t          state;
  logic [IDX_W-1:0]    bit_idx;
  logic [ADDR_W-1:0]   addr_q;
  logic [CMD_BITS-1:0] cmd_sh;
  logic [DATA_W-1:0]   data_sh;
  logic                last_bit, in_data;

  assign last_bit = (bit_idx == IDX_W'(TOTAL_BITS - 1));
  assign in_data  = (bit_idx >= IDX_W'(CMD_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_START;
      bit_idx <= '0;
      addr_q  <= '0;
      cmd_sh  <= '0;
      data_sh <= '0;
    end else begin
      unique case (state)
        ST_START: state <= detect ? ST_GAP : ST_DONE;
        ST_GAP: if (tick) begin
          state   <= ST_LO;
          bit_idx <= '0;
          cmd_sh  <= {READ_PREFIX, addr_q};
        end
        ST_LO: if (tick) state <= ST_HI;
        ST_HI: if (tick) begin
          cmd_sh <= {cmd_sh[CMD_BITS-2:0], 1'b0};
          if (in_data) data_sh <= {data_sh[DATA_W-2:0], ee_do};
          if (last_bit) state <= ST_WAIT;
          else begin
            bit_idx <= bit_idx + 1'b1;
            state   <= ST_LO;
          end
        end
        ST_WAIT: if (word_ready) begin
          if (addr_q == LAST_ADDR) state <= ST_DONE;
          else begin
            addr_q <= addr_q + 1'b1;
            state  <= ST_GAP;
          end
        end
        ST_DONE: state <= ST_DONE;
        default: state <= ST_DONE;
      endcase
    end
  end

  assign eng_cs     = (state == ST_LO) || (state == ST_HI);
  assign eng_sk     = (state == ST_HI);
  assign eng_di     = eng_cs && cmd_sh[CMD_BITS-1];
  assign busy       = (state == ST_GAP) || eng_cs || (state == ST_WAIT);
  assign done       = (state == ST_DONE);
  assign word_valid = (state == ST_WAIT);
  assign word_addr  = addr_q;
  assign word_data  = data_sh;

  a_r6_sk_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    eng_sk |-> eng_cs);
  a_r6_sk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(eng_sk));
  a_r7_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_cs) |=> !eng_cs);
  a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data) && $stable(word_addr)));
endmodule

// File: rtl/eeprom_loader.sv
module eeprom_loader #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int NUM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ee_sk_sense,
  input  logic              ee_do,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              host_wr,
  input  logic [2:0]        host_wdata,
  output logic [4:0]        host_rdata,
  output logic              load_done,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [ADDR_W-1:0] word_addr,
  output logic [DATA_W-1:0] word_data
);
  logic       detect, busy;
  logic       eng_cs, eng_sk, eng_di;
  logic [2:0] pin_reg;

  eel_presence u_presence (
    .clk      (clk),
    .rst_n    (rst_n),
    .sk_sense (ee_sk_sense),
    .detect   (detect)
  );

  eel_engine #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_WORDS (NUM_WORDS)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .detect     (detect),
    .ee_do      (ee_do),
    .eng_cs     (eng_cs),
    .eng_sk     (eng_sk),
    .eng_di     (eng_di),
    .busy       (busy),
    .done       (load_done),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .word_addr  (word_addr),
    .word_data  (word_data)
  );

  eel_host_port u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .pin_reg    (pin_reg)
  );

  assign ee_cs      = busy ? eng_cs : pin_reg[2];
  assign ee_sk      = busy ? eng_sk : pin_reg[1];
  assign ee_di      = busy ? eng_di : pin_reg[0];
  assign host_rdata = {detect, busy, pin_reg[2], pin_reg[1], ee_do};

  a_r2_idle_without_eeprom: assert property (@(posedge clk) disable iff (!rst_n)
    !detect |-> !busy);
  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_done && busy));
endmodule

// File: tb/eeprom_loader_test.sv
module eeprom_loader_test;
  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int NW  = 64;
  localparam int CMD = 3 + AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          ee_sk_sense = 1'b0;
  logic          ee_do;
  logic          ee_cs, ee_sk, ee_di;
  logic          host_wr = 1'b0;
  logic [2:0]    host_wdata = '0;
  logic [4:0]    host_rdata;
  logic          load_done, word_valid;
  logic          word_ready = 1'b1;
  logic [AW-1:0] word_addr;
  logic [DW-1:0] word_data;

  eeprom_loader #(.ADDR_W(AW), .DATA_W(DW), .NUM_WORDS(NW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ee_sk_sense(ee_sk_sense), .ee_do(ee_do),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .load_done(load_done),
    .word_valid(word_valid), .word_ready(word_ready), .word_addr(word_addr),
    .word_data(word_data)
  );

  int compared = 0;
  int mismatched = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mem_word(input int a);
    return DW'(a * 32'h2f1b) ^ 16'h5ac3;
  endfunction

  // stimulus knobs
  int  tick_div = 1;
  int  tcnt = 0;
  bit  bp_mode = 1'b0;
  bit  exp_det = 1'b0;
  logic host_do_val = 1'b0;
  logic [7:0] lfsr = 8'h01;

  always @(posedge clk) begin
    if (tcnt >= tick_div - 1) begin tcnt <= 0; tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; tick <= 1'b0; end
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    word_ready <= bp_mode ? lfsr[0] : 1'b1;
  end

  // reference state
  int   cyc = 0;
  bit   finished = 1'b0;
  bit   exp_busy = 1'b0;
  logic [2:0] mh = '0;
  logic model_do = 1'b0;
  int   bitcnt = 0;
  logic [CMD-1:0] cmd_q = '0;
  int   cmd_words = 0;
  int   exp_addr = 0;
  int   gap_ticks = 0;
  logic prev_sk = 1'b0, prev_cs = 1'b0, prev_tick = 1'b0;
  logic prev_valid = 1'b0, prev_ready = 1'b0;
  logic [DW-1:0] prev_data = '0;
  logic [AW-1:0] prev_addr = '0;

  assign ee_do = exp_busy ? model_do : host_do_val;

  always @(posedge clk) begin
    if (!rst_n) begin cyc <= 0; mh <= '0; end
    else begin
      cyc <= cyc + 1;
      if (host_wr && !exp_busy) mh <= host_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      finished = 1'b0; exp_busy = 1'b0; bitcnt = 0; cmd_words = 0; exp_addr = 0;
      gap_ticks = 0; model_do = 1'b0; prev_valid = 1'b0;
    end else if (cyc >= 1) begin
      exp_busy = exp_det && !finished;
      chk(host_rdata[4] == exp_det, "R1 detect", int'(host_rdata[4]), int'(exp_det));
      chk(host_rdata[3] == exp_busy, "R9 busy", int'(host_rdata[3]), int'(exp_busy));
      chk(load_done == (!exp_det || finished), "R11 done", int'(load_done), int'(!exp_det || finished));
      if (!exp_busy) begin
        chk({ee_cs, ee_sk, ee_di} == mh, "R10 pins", int'({ee_cs, ee_sk, ee_di}), int'(mh));
        chk(host_rdata[2:0] == {mh[2:1], host_do_val}, "R10 readback",
            int'(host_rdata[2:0]), int'({mh[2:1], host_do_val}));
        if (!exp_det) chk(!word_valid, "R2 no word", int'(word_valid), 0);
      end else begin
        chk(!(ee_sk && !ee_cs), "R6 sk inside cs", int'({ee_cs, ee_sk}), 3);
        if (ee_sk != prev_sk) chk(prev_tick, "R6 sk paced by tick", int'(prev_tick), 1);
        // memory model
        if (!ee_cs && prev_cs) bitcnt = 0;
        if (!ee_cs && tick) gap_ticks++;
        if (ee_cs && !prev_cs) begin
          if (cmd_words > 0) chk(gap_ticks >= 1, "R7 cs gap", gap_ticks, 1);
          gap_ticks = 0;
        end
        if (ee_cs && ee_sk && !prev_sk) begin
          if (bitcnt < CMD) begin
            cmd_q = {cmd_q[CMD-2:0], ee_di};
            if (bitcnt == CMD - 1) begin
              chk(cmd_q[CMD-1:AW] == 3'b110, "R4 opcode", int'(cmd_q[CMD-1:AW]), 6);
              chk(int'(cmd_q[AW-1:0]) == cmd_words, "R4 address", int'(cmd_q[AW-1:0]), cmd_words);
              cmd_words++;
            end
          end else begin
            model_do = mem_word(cmd_words - 1)[DW-1-(bitcnt-CMD)];
          end
          bitcnt++;
        end
      end
      if (prev_valid && !prev_ready) begin
        chk(word_valid && word_data == prev_data && word_addr == prev_addr, "R8 hold",
            int'(word_data), int'(prev_data));
      end
      if (word_valid && word_ready) begin
        chk(int'(word_addr) == exp_addr, "R3 order", int'(word_addr), exp_addr);
        chk(word_data == mem_word(exp_addr), "R5 data", int'(word_data), int'(mem_word(exp_addr)));
        if (exp_addr == NW - 1) finished = 1'b1;
        exp_addr++;
      end
    end
    prev_sk = ee_sk; prev_cs = ee_cs; prev_tick = tick;
    prev_valid = word_valid; prev_ready = word_ready;
    prev_data = word_data; prev_addr = word_addr;
  end

  task automatic do_reset(input bit sense);
    @(posedge clk); #1;
    rst_n = 1'b0; ee_sk_sense = ~sense; exp_det = sense;
    repeat (2) @(posedge clk);
    #1 ee_sk_sense = sense;
    @(posedge clk); #1;
    rst_n = 1'b1; ee_sk_sense = ~sense;
  endtask

  task automatic hwrite(input logic [2:0] v);
    @(posedge clk); #1 host_wr = 1'b1; host_wdata = v;
    @(posedge clk); #1 host_wr = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!finished && n < 50000) begin @(posedge clk); n++; end
    if (!finished) chk(1'b0, {tag, " watchdog"}, n, 0);
    repeat (3) @(posedge clk);
    chk(exp_addr == NW, "R3 word count", exp_addr, NW);
  endtask

  initial begin
    // scenario A: no memory fitted, host bit-bang
    tick_div = 1; bp_mode = 1'b0;
    do_reset(1'b0);
    repeat (4) @(posedge clk);
    hwrite(3'b101);
    #1 host_do_val = 1'b1;
    repeat (2) @(posedge clk);
    hwrite(3'b010);
    #1 host_do_val = 1'b0;
    repeat (2) @(posedge clk);
    hwrite(3'b111);
    repeat (2) @(posedge clk);

    // scenario B: memory present, fast ticks, host write during load is dropped
    do_reset(1'b1);
    repeat (40) @(posedge clk);
    hwrite(3'b111);
    wait_done("R3 run B");
    repeat (2) @(posedge clk);
    hwrite(3'b110);
    repeat (2) @(posedge clk);

    // scenario C: slow ticks and random back-pressure
    tick_div = 3; bp_mode = 1'b1;
    do_reset(1'b1);
    wait_done("R3 run C");
    bp_mode = 1'b0;
    hwrite(3'b001);
    repeat (2) @(posedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule